// File: doc/BRIEF.md
# Eight-Channel Playback and Silence Sequencer

This block keeps the control state of eight independent playback channels. A host issues commands that carry either an 8-bit channel mask or a channel index and a silence length. The commands start, halt, repeat or insert silence on a channel. Each playing channel walks a 24-bit sample address from its start address up to its stop address. It advances one step per pulse of that channel's sample-rate tick, and each step raises an address-valid strobe for a downstream fetch unit.

A silence segment instead counts down a whole number of 4 ms units. Each channel has a one-deep pending slot, so the next phrase or silence can be queued while the current one plays. The pending entry is taken up at the phrase boundary. The start and stop addresses are read from input ports at the moment a queued phrase becomes active.

Per-channel `ready` tells the host that the pending slot is free. Per-channel `quiet` tells it that nothing is playing or queued. Per-channel `mute` tells the sample path to hold its output at mid-scale.

Top module: `chan_play_seq`

## Requirements
- R1: Command encoding on `cmd_op` is 0 = start, 1 = stop, 2 = loop, 3 = silence. For start, stop and loop, bit n of `cmd_mask` selects channel n, which is the (n+1)-th channel. Silence selects one channel through `cmd_chan`.
- R2: A start accepted on a channel whose `ready` is high fills its pending slot at the command edge. From the next cycle, `ready` and `quiet` are low. An idle channel takes the entry at the following edge, after which `ready` is high again and `mute` is low.
- R3: A start or silence command for a channel whose `ready` is low has no effect. The queued entry and everything after it are unchanged.
- R4: A stop for a channel makes `mute`, `ready` and `quiet` high from the next cycle. It discards any queued entry, and no further `addr_valid` appears on that channel until a new command arrives.
- R5: During playback, `addr_valid[n]` is high exactly in the cycles where `sample_tick[n]` is high. `addr_out` starts at the start address and rises by one per tick. The phrase ends after the tick on which the address is greater than or equal to the stop address. Between ticks the address holds.
- R6: At the end of a phrase, a queued phrase starts on the same edge. Its start and stop addresses are read from the address inputs on that edge.
- R7: A loop command writes every channel's loop flag from `cmd_mask`. At phrase end, a channel with its flag set restarts from its start address. Clearing the flag lets the current pass finish, after which the queue is served.
- R8: A silence of length M (1 to 255) keeps the channel active, with `mute` high and no `addr_valid`, for exactly M × `UNIT_CYCLES` cycles. This is 4 ms per unit at the default setting. M = 0 is ignored.
- R9: A silence accepted while a phrase plays starts right after that phrase ends.
- R10: After reset, every channel has `ready`, `quiet` and `mute` high and `addr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Command code (R1) |
| cmd_mask | input | 8 | Channel mask for start, stop and loop |
| cmd_chan | input | 3 | Channel index for silence |
| cmd_len | input | 8 | Silence length in 4 ms units |
| sample_tick | input | 8 | Per-channel sample-rate tick |
| start_addr | input | 192 | Per-channel phrase start address, channel n in bits 24n+23..24n |
| stop_addr | input | 192 | Per-channel phrase stop address, same packing |
| ready | output | 8 | Pending slot free |
| quiet | output | 8 | Nothing active or queued |
| mute | output | 8 | Output sample held at mid-scale |
| addr_valid | output | 8 | Sample address strobe |
| addr_out | output | 192 | Per-channel current sample address |

## Verification
The properties assume that `cmd_valid` is a single-cycle strobe carrying exactly one operation. They also assume that `sample_tick` bits are synchronous pulses of at most one cycle. The bench drives every command and tick as a one-cycle pulse on the falling clock edge. It changes the address inputs only while no takeover for that channel can happen. The silence unit is shortened through the `UNIT_CYCLES` parameter so that silence windows are short enough to count edge by edge.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;

    localparam int LEN_W  = 8;
    localparam int OP_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_START   = 2'd0,
        OP_STOP    = 2'd1,
        OP_LOOP    = 2'd2,
        OP_SILENCE = 2'd3
    } op_e;

    // Activity kind of the running slot and of the pending slot.
    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_PLAY = 2'd1,
        SLOT_SIL  = 2'd2
    } slot_e;

    // Per-channel request decoded from one host command.
    typedef struct packed {
        logic             start;
        logic             stop;
        logic             loop_wr;
        logic             loop_val;
        logic             sil;
        logic [LEN_W-1:0] sil_len;
    } chan_req_t;

    function automatic logic sel_bit(input logic [7:0] mask, input int idx);
        return mask[idx];
    endfunction

endpackage

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode
    import chan_seq_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             cmd_valid,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic [NCH-1:0]   cmd_mask,
    input  logic [CH_W-1:0]  cmd_chan,
    input  logic [LEN_W-1:0] cmd_len,
    output chan_req_t        req_o [NCH]
);

    op_e op;
    assign op = op_e'(cmd_op);

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        always_comb begin
            req_o[g]          = '0;
            req_o[g].sil_len  = cmd_len;
            req_o[g].loop_val = cmd_mask[g];
            if (cmd_valid) begin
                unique case (op)
                    OP_START:   req_o[g].start   = cmd_mask[g];
                    OP_STOP:    req_o[g].stop    = cmd_mask[g];
                    OP_LOOP:    req_o[g].loop_wr = 1'b1;
                    OP_SILENCE: req_o[g].sil     = (cmd_chan == CH_W'(g));
                    default:    req_o[g]         = req_o[g];
                endcase
            end
        end
    end

endmodule

// File: rtl/chan_slot.sv
module chan_slot
    import chan_seq_pkg::*;
#(
    parameter int AW          = 24,
    parameter int UNIT_CYCLES = 16384,
    localparam int MAX_SIL    = ((1 << LEN_W) - 1) * UNIT_CYCLES,
    localparam int CW         = $clog2(MAX_SIL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_req_t     req,
    input  logic          tick,
    input  logic [AW-1:0] start_in,
    input  logic [AW-1:0] stop_in,
    output logic          ready,
    output logic          quiet,
    output logic          mute,
    output logic          addr_valid,
    output logic [AW-1:0] addr
);

    slot_e            act_q, pend_q;
    logic [LEN_W-1:0] pend_len_q;
    logic             loop_q;
    logic [AW-1:0]    addr_q, start_q, stop_q;
    logic [CW-1:0]    sil_cnt_q;

    logic at_end, sil_end, slot_free, take_start, take_sil;

    always_comb begin
        at_end     = (act_q == SLOT_PLAY) && tick && (addr_q >= stop_q);
        sil_end    = (act_q == SLOT_SIL) && (sil_cnt_q == CW'(1));
        slot_free  = (act_q == SLOT_NONE) || (at_end && !loop_q) || sil_end;
        take_start = req.start && (pend_q == SLOT_NONE);
        take_sil   = req.sil && (pend_q == SLOT_NONE) && (req.sil_len != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q      <= SLOT_NONE;
            pend_q     <= SLOT_NONE;
            pend_len_q <= '0;
            loop_q     <= 1'b0;
            addr_q     <= '0;
            start_q    <= '0;
            stop_q     <= '0;
            sil_cnt_q  <= '0;
        end else begin
            if (req.loop_wr) loop_q <= req.loop_val;
            if (req.stop) begin
                act_q  <= SLOT_NONE;
                pend_q <= SLOT_NONE;
            end else begin
                if (act_q == SLOT_PLAY && tick) begin
                    if (!at_end)     addr_q <= addr_q + AW'(1);
                    else if (loop_q) addr_q <= start_q;
                end
                if (act_q == SLOT_SIL) sil_cnt_q <= sil_cnt_q - CW'(1);
                if (slot_free) begin
                    unique case (pend_q)
                        SLOT_PLAY: begin
                            act_q   <= SLOT_PLAY;
                            addr_q  <= start_in;
                            start_q <= start_in;
                            stop_q  <= stop_in;
                        end
                        SLOT_SIL: begin
                            act_q     <= SLOT_SIL;
                            sil_cnt_q <= CW'(pend_len_q) * CW'(UNIT_CYCLES);
                        end
                        default: act_q <= SLOT_NONE;
                    endcase
                    pend_q <= SLOT_NONE;
                end
                if (take_start) begin
                    pend_q <= SLOT_PLAY;
                end else if (take_sil) begin
                    pend_q     <= SLOT_SIL;
                    pend_len_q <= req.sil_len;
                end
            end
        end
    end

    assign ready      = (pend_q == SLOT_NONE);
    assign quiet      = (act_q == SLOT_NONE) && (pend_q == SLOT_NONE);
    assign mute       = (act_q != SLOT_PLAY);
    assign addr_valid = (act_q == SLOT_PLAY) && tick;
    assign addr       = addr_q;

endmodule

// File: rtl/chan_play_seq.sv
module chan_play_seq
    import chan_seq_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int AW          = 24,
    parameter int UNIT_CYCLES = 16384,
    localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [NCH-1:0]    cmd_mask,
    input  logic [CH_W-1:0]   cmd_chan,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [NCH-1:0]    sample_tick,
    input  logic [NCH*AW-1:0] start_addr,
    input  logic [NCH*AW-1:0] stop_addr,
    output logic [NCH-1:0]    ready,
    output logic [NCH-1:0]    quiet,
    output logic [NCH-1:0]    mute,
    output logic [NCH-1:0]    addr_valid,
    output logic [NCH*AW-1:0] addr_out
);

    chan_req_t req [NCH];

    chan_cmd_decode #(.NCH(NCH)) dec_i (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_mask  (cmd_mask),
        .cmd_chan  (cmd_chan),
        .cmd_len   (cmd_len),
        .req_o     (req)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chan_slot #(.AW(AW), .UNIT_CYCLES(UNIT_CYCLES)) slot_i (
            .clk        (clk),
            .rst        (rst),
            .req        (req[g]),
            .tick       (sample_tick[g]),
            .start_in   (start_addr[g*AW +: AW]),
            .stop_in    (stop_addr[g*AW +: AW]),
            .ready      (ready[g]),
            .quiet      (quiet[g]),
            .mute       (mute[g]),
            .addr_valid (addr_valid[g]),
            .addr       (addr_out[g*AW +: AW])
        );
    end

endmodule

// File: rtl/chan_play_seq_chk.sv
module chan_play_seq_chk
    import chan_seq_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int AW   = 24,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [OP_W-1:0]   cmd_op,
    input logic [NCH-1:0]    cmd_mask,
    input logic [CH_W-1:0]   cmd_chan,
    input logic [LEN_W-1:0]  cmd_len,
    input logic [NCH-1:0]    sample_tick,
    input logic [NCH-1:0]    ready,
    input logic [NCH-1:0]    quiet,
    input logic [NCH-1:0]    mute,
    input logic [NCH-1:0]    addr_valid,
    input logic [NCH*AW-1:0] addr_out
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        logic stop_hit, start_hit, sil_zero_hit;
        assign stop_hit     = cmd_valid && (cmd_op == OP_STOP) && cmd_mask[g];
        assign start_hit    = cmd_valid && (cmd_op == OP_START) && cmd_mask[g];
        assign sil_zero_hit = cmd_valid && (cmd_op == OP_SILENCE) &&
                              (cmd_chan == CH_W'(g)) && (cmd_len == '0);

        assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
            start_hit && ready[g] |=> !quiet[g]);

        assert_stop_idle_R4: assert property (@(posedge clk) disable iff (rst)
            stop_hit |=> quiet[g] && ready[g] && mute[g]);

        assert_strobe_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
            addr_valid[g] |-> sample_tick[g] && !mute[g]);

        assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
            !mute[g] && !sample_tick[g] && !stop_hit |=> $stable(addr_out[g*AW +: AW]));

        assert_zero_silence_R8: assert property (@(posedge clk) disable iff (rst)
            sil_zero_hit && quiet[g] |=> quiet[g]);
    end

endmodule

bind chan_play_seq chan_play_seq_chk #(.NCH(NCH), .AW(AW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_mask    (cmd_mask),
    .cmd_chan    (cmd_chan),
    .cmd_len     (cmd_len),
    .sample_tick (sample_tick),
    .ready       (ready),
    .quiet       (quiet),
    .mute        (mute),
    .addr_valid  (addr_valid),
    .addr_out    (addr_out)
);

// File: tb/chan_play_seq_tb_top.sv
module chan_play_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 8;
    localparam int AW   = 24;
    localparam int UNIT = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = '0;
    logic [7:0]        cmd_mask = '0;
    logic [2:0]        cmd_chan = '0;
    logic [7:0]        cmd_len = '0;
    logic [NCH-1:0]    sample_tick = '0;
    logic [NCH*AW-1:0] start_addr = '0;
    logic [NCH*AW-1:0] stop_addr = '0;
    logic [NCH-1:0]    ready, quiet, mute, addr_valid;
    logic [NCH*AW-1:0] addr_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_play_seq #(.NCH(NCH), .AW(AW), .UNIT_CYCLES(UNIT)) dut_i (
        .clk, .rst, .cmd_valid, .cmd_op, .cmd_mask, .cmd_chan, .cmd_len,
        .sample_tick, .start_addr, .stop_addr,
        .ready, .quiet, .mute, .addr_valid, .addr_out
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_addr(input int ch, input int s, input int e);
        start_addr[ch*AW +: AW] = AW'(s);
        stop_addr[ch*AW +: AW]  = AW'(e);
    endtask

    task automatic issue(input int op, input int mask, input int chan, input int len);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_mask  = 8'(mask);
        cmd_chan  = 3'(chan);
        cmd_len   = 8'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic tick_expect(input int ch, input bit valid, input int exp_addr, input string tag);
        sample_tick = '0;
        sample_tick[ch] = 1'b1;
        #1;
        check({tag, " valid"}, 32'(addr_valid[ch]), 32'(valid));
        if (valid) check({tag, " addr"}, 32'(addr_out[ch*AW +: AW]), 32'(exp_addr));
        @(negedge clk);
        sample_tick = '0;
    endtask

    task automatic t_reset;
        check("R10 ready", 32'(ready), 32'hFF);
        check("R10 quiet", 32'(quiet), 32'hFF);
        check("R10 mute", 32'(mute), 32'hFF);
        check("R10 addr_valid", 32'(addr_valid), 32'h0);
    endtask

    task automatic t_start_play;
        set_addr(0, 'h100, 'h103);
        issue(0, 'h01, 0, 0);
        check("R2 queued ready", 32'(ready[0]), 0);
        check("R2 queued quiet", 32'(quiet[0]), 0);
        @(negedge clk);
        check("R2 taken ready", 32'(ready[0]), 1);
        check("R2 taken mute", 32'(mute[0]), 0);
        @(negedge clk);
        check("R5 hold", 32'(addr_out[0 +: AW]), 'h100);
        for (int i = 0; i < 4; i++) tick_expect(0, 1, 'h100 + i, "R5 walk");
        check("R5 end quiet", 32'(quiet[0]), 1);
        check("R5 end mute", 32'(mute[0]), 1);
    endtask

    task automatic t_mask_map;
        set_addr(7, 'h10, 'h20);
        issue(0, 'h80, 0, 0);
        check("R1 mask bit7 chan", 32'(quiet), 32'h7F);
        issue(1, 'h80, 0, 0);
        check("R1 stop bit7", 32'(quiet), 32'hFF);
    endtask

    task automatic t_queue_ignore;
        set_addr(0, 'h400, 'h401);
        issue(0, 'h01, 0, 0);
        @(negedge clk);
        set_addr(0, 'h500, 'h500);
        issue(0, 'h01, 0, 0);
        check("R3 pend ready low", 32'(ready[0]), 0);
        issue(0, 'h01, 0, 0);
        issue(3, 0, 0, 5);
        check("R3 still pending", 32'(ready[0]), 0);
        tick_expect(0, 1, 'h400, "R6 first");
        tick_expect(0, 1, 'h401, "R6 first");
        check("R6 taken ready", 32'(ready[0]), 1);
        check("R6 no gap mute", 32'(mute[0]), 0);
        tick_expect(0, 1, 'h500, "R6 second");
        check("R3 ignored requests", 32'(quiet[0]), 1);
    endtask

    task automatic t_stop;
        set_addr(4, 'h600, 'h6FF);
        issue(0, 'h10, 0, 0);
        @(negedge clk);
        issue(0, 'h10, 0, 0);
        tick_expect(4, 1, 'h600, "R4 before");
        issue(1, 'h10, 0, 0);
        check("R4 quiet", 32'(quiet[4]), 1);
        check("R4 ready", 32'(ready[4]), 1);
        check("R4 mute", 32'(mute[4]), 1);
        tick_expect(4, 0, 0, "R4 no strobe");
        repeat (2) @(negedge clk);
        check("R4 queue dropped", 32'(quiet[4]), 1);
    endtask

    task automatic t_loop;
        set_addr(1, 'h200, 'h201);
        issue(2, 'h02, 0, 0);
        issue(0, 'h02, 0, 0);
        @(negedge clk);
        tick_expect(1, 1, 'h200, "R7 pass1");
        tick_expect(1, 1, 'h201, "R7 pass1");
        check("R7 still playing", 32'(quiet[1]), 0);
        tick_expect(1, 1, 'h200, "R7 restart");
        issue(2, 'h00, 0, 0);
        check("R7 clear mid pass", 32'(mute[1]), 0);
        tick_expect(1, 1, 'h201, "R7 finish pass");
        check("R7 ended", 32'(quiet[1]), 1);
    endtask

    task automatic t_silence;
        issue(3, 0, 2, 3);
        check("R8 queued", 32'(quiet[2]), 0);
        @(negedge clk);
        check("R8 mute", 32'(mute[2]), 1);
        check("R8 ready", 32'(ready[2]), 1);
        tick_expect(2, 0, 0, "R8 no strobe");
        repeat (10) @(negedge clk);
        check("R8 last unit", 32'(quiet[2]), 0);
        @(negedge clk);
        check("R8 length done", 32'(quiet[2]), 1);
        issue(3, 0, 2, 0);
        check("R8 zero length", 32'(quiet[2]), 1);
        check("R8 zero ready", 32'(ready[2]), 1);
    endtask

    task automatic t_silence_after;
        set_addr(3, 'h300, 'h300);
        issue(0, 'h08, 0, 0);
        @(negedge clk);
        issue(3, 0, 3, 2);
        check("R9 still playing", 32'(mute[3]), 0);
        tick_expect(3, 1, 'h300, "R9 phrase");
        check("R9 silence mute", 32'(mute[3]), 1);
        check("R9 silence busy", 32'(quiet[3]), 0);
        repeat (7) @(negedge clk);
        check("R9 silence tail", 32'(quiet[3]), 0);
        @(negedge clk);
        check("R9 silence done", 32'(quiet[3]), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_start_play();
        t_mask_map();
        t_queue_ignore();
        t_stop();
        t_loop();
        t_silence();
        t_silence_after();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule